// File: doc/BRIEF.md
# Active Tamper Mesh Comparator

The block guards a shield trace. It drives a pseudo-random bit stream onto an output pin. A trace outside the chip routes that pin back to an input pin. At the end of each write/read period the block compares the returned bit with the bit it drove during that period. A cut trace, or a trace forced to a fixed level, soon gives a mismatch. That mismatch becomes a tamper event.

The `div_i` input sets the length of one period. Each period lasts `div_i + 1` clock cycles. When the block is enabled, the first period only lets the loop settle and is not compared. Two detection policies are available:

- **Unfiltered:** one mismatch is enough to raise an event.
- **Filtered:** the block votes over the last four comparison results. It raises an event when at least two of them are mismatches.

The tamper flag stays set until a write-one-to-clear strobe clears it. The event pulse marks the cycle in which the flag first sets.

Top module: `tamper_mesh_cmp`

## Requirements
- R1: After reset, `tamper_flag`, `tamper_pulse` and `mesh_out` are all 0.
- R2: While `en` is low, `mesh_out` is 0 and no tamper event occurs, whatever the level on `mesh_in`.
- R3: The drive pattern comes from a 16-bit LFSR.
  - Next state is `{s[0]^s[2]^s[3]^s[5], s[15:1]}` and `mesh_out` is `s[0]`.
  - The state is loaded with seed 16'hACE1 while the block is disabled.
  - During the settle period the block drives the seed's bit 0. The LFSR then advances once at the end of every period.
- R4: The first period after `en` rises is a settle period. Its input is never compared.
- R5: With `filt_en` low, one mismatch at the end of a compared period sets `tamper_flag`. The flag is visible in the cycle after the period's last clock edge.
- R6: With `filt_en` high, the event is raised when the current comparison and the three comparisons before it hold at least two mismatches. One isolated mismatch raises nothing, and neither do two mismatches four periods apart.
- R7: The filter history is cleared while the block is disabled.
  - Mismatches from an earlier run never count after `en` rises again.
  - Two mismatches in the first two compared periods of a new run do raise an event.
- R8: `tamper_flag` stays set until `flag_clr` is high at a clock edge. The clear also works while the block is disabled. If a detection and a clear fall on the same edge, the detection wins.
- R9: `tamper_pulse` is high for exactly one cycle, in the cycle where `tamper_flag` goes from 0 to 1.
- R10: Each period lasts `div_i + 1` clock cycles, and `mesh_out` holds steady through it. A value of 0 gives a one-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables driving and comparing |
| div_i | input | DIV_W | Period length minus one, in clock cycles |
| filt_en | input | 1 | Selects the 2-of-4 vote instead of single-sample detection |
| flag_clr | input | 1 | Write-one-to-clear strobe for the tamper flag |
| mesh_in | input | 1 | Returned bit from the shield trace |
| mesh_out | output | 1 | Driven bit onto the shield trace |
| tamper_flag | output | 1 | Sticky tamper indication |
| tamper_pulse | output | 1 | One-cycle event marker |

## Verification
The bench builds the block with an 8-bit divider and otherwise default parameters, so the full 16-bit LFSR and the 2-of-4 window are in place.

It runs with period settings 3 and 0:
- The four-cycle period makes the held-drive check and the clear inside a period observable.
- The one-cycle period puts the clear strobe and a detection on the same edge, which shows the priority.

A fault term XORed into the loop return injects mismatches in chosen periods. Vote patterns close to the threshold show where detection starts and stops.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } tmc_state_e;

endpackage

// File: rtl/tmc_prescaler.sv
module tmc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // End of period; >= keeps the count sane if div shrinks mid-period
    assign tick = run && (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmc_lfsr.sv
module tmc_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    SEED = 16'hACE1,
    parameter logic [W-1:0]    TAPS = 16'h002D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic bit_o
);

    logic [W-1:0] q;
    logic         fb;

    assign fb    = ^(q & TAPS);
    assign bit_o = q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (load) begin
            q <= SEED;
        end else if (step) begin
            q <= {fb, q[W-1:1]};
        end
    end

endmodule

// File: rtl/tmc_vote_filter.sv
module tmc_vote_filter #(
    parameter int WIN    = 4,
    parameter int THRESH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic mm,
    input  logic filt_en,
    output logic hit
);

    localparam int CW = $clog2(WIN + 1);

    logic [WIN-1:0] hist_q;
    logic [WIN-1:0] hist_nx;
    logic [CW-1:0]  pop;

    assign hist_nx = {hist_q[WIN-2:0], mm};

    always_comb begin
        pop = '0;
        for (int i = 0; i < WIN; i++) begin
            pop = pop + CW'(hist_nx[i]);
        end
    end

    assign hit = smp && (filt_en ? (pop >= CW'(THRESH)) : mm);

    // Cleared entries read as "no mismatch", so a partly filled window
    // only counts the samples taken since enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (smp) begin
            hist_q <= hist_nx;
        end
    end

endmodule

// File: rtl/tamper_mesh_cmp.sv
module tamper_mesh_cmp
    import tmc_pkg::*;
#(
    parameter int                 DIV_W     = 16,
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'h002D,
    parameter int                 WIN       = 4,
    parameter int                 THRESH    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_i,
    input  logic             filt_en,
    input  logic             flag_clr,
    input  logic             mesh_in,
    output logic             mesh_out,
    output logic             tamper_flag,
    output logic             tamper_pulse
);

    tmc_state_e state_q, state_d;

    logic tick;
    logic run;
    logic lfsr_load;
    logic lfsr_step;
    logic lfsr_bit;
    logic drive_on;
    logic smp;
    logic filt_clr;
    logic mm;
    logic hit;
    logic flag_q;
    logic pulse_q;

    assign run = en && (state_q != ST_OFF);

    tmc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div_i),
        .tick (tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: OFF->SETTLE on enable, SETTLE->RUN at first period end,
    // any state -> OFF on disable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (en) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!en)       state_d = ST_OFF;
                else if (tick) state_d = ST_RUN;
            end
            ST_RUN:    if (!en) state_d = ST_OFF;
            default:   state_d = ST_OFF;
        endcase
    end

    // State outputs
    always_comb begin
        drive_on  = 1'b0;
        lfsr_load = 1'b0;
        filt_clr  = 1'b0;
        lfsr_step = 1'b0;
        smp       = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                lfsr_load = 1'b1;
                filt_clr  = 1'b1;
            end
            ST_SETTLE: begin
                drive_on  = 1'b1;
                lfsr_step = tick;
            end
            ST_RUN: begin
                drive_on  = 1'b1;
                lfsr_step = tick;
                smp       = tick;
            end
            default: begin
                lfsr_load = 1'b1;
                filt_clr  = 1'b1;
            end
        endcase
    end

    tmc_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (lfsr_load),
        .step (lfsr_step),
        .bit_o(lfsr_bit)
    );

    assign mesh_out = drive_on & lfsr_bit;
    assign mm       = mesh_in ^ mesh_out;

    tmc_vote_filter #(.WIN(WIN), .THRESH(THRESH)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (filt_clr),
        .smp    (smp),
        .mm     (mm),
        .filt_en(filt_en),
        .hit    (hit)
    );

    // Sticky flag, detection has priority over the clear strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit && !flag_q;
            if (hit) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign tamper_flag  = flag_q;
    assign tamper_pulse = pulse_q;

endmodule

// File: rtl/tmc_checker.sv
module tmc_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic filt_en,
    input logic flag_clr,
    input logic mesh_in,
    input logic mesh_out,
    input logic tamper_flag,
    input logic tamper_pulse,
    input logic sample_stb
);

    assert_pulse_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_pulse |-> tamper_flag);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_pulse |=> !tamper_pulse);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (mesh_out == 1'b0) && !tamper_pulse);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_flag && !flag_clr |=> tamper_flag);

    assert_raw_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb && !filt_en && (mesh_in != mesh_out) |=> tamper_flag);

    assert_flag_from_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tamper_flag) |-> $past(sample_stb));

endmodule

bind tamper_mesh_cmp tmc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .filt_en     (filt_en),
    .flag_clr    (flag_clr),
    .mesh_in     (mesh_in),
    .mesh_out    (mesh_out),
    .tamper_flag (tamper_flag),
    .tamper_pulse(tamper_pulse),
    .sample_stb  (smp)
);

// File: tb/tamper_mesh_cmp_tb_top.sv
module tamper_mesh_cmp_tb_top;

    localparam int          DIV_W = 8;
    localparam logic [15:0] SEED  = 16'hACE1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             filt_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic             fault = 1'b0;
    logic             mesh_in;
    logic             mesh_out;
    logic             tamper_flag;
    logic             tamper_pulse;

    int          checks = 0;
    int          errors = 0;
    int          dper = 4;
    logic [15:0] model;
    bit          done = 0;

    always #10 clk = ~clk;

    assign mesh_in = mesh_out ^ fault;

    tamper_mesh_cmp #(.DIV_W(DIV_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .div_i       (div_i),
        .filt_en     (filt_en),
        .flag_clr    (flag_clr),
        .mesh_in     (mesh_in),
        .mesh_out    (mesh_out),
        .tamper_flag (tamper_flag),
        .tamper_pulse(tamper_pulse)
    );

    function automatic logic [15:0] adv(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic set_div(input int d);
        div_i = DIV_W'(d);
        dper  = d + 1;
    endtask

    // Raise enable; settle period runs with the given fault level
    task automatic start_run(input logic settle_fault);
        @(negedge clk);
        en    = 1'b1;
        fault = settle_fault;
        model = SEED;
        @(negedge clk);
        check("R3", "settle drive", mesh_out, model[0]);
        repeat (dper) @(negedge clk);
        model = adv(model);
    endtask

    // One compared period; results sampled after its last edge
    task automatic sample(input logic f, input logic clr, output logic fl, output logic pl);
        fault    = f;
        flag_clr = clr;
        for (int i = 0; i < dper; i++) begin
            check(i == 0 ? "R3" : "R10", "drive bit", mesh_out, model[0]);
            @(negedge clk);
            if (i == 0) flag_clr = 1'b0;
        end
        fl    = tamper_flag;
        pl    = tamper_pulse;
        model = adv(model);
    endtask

    task automatic stop_run();
        @(negedge clk);
        en    = 1'b0;
        fault = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", "disabled drive", mesh_out, 1'b0);
    endtask

    task automatic clear_idle();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8", "idle clear", tamper_flag, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "flag", tamper_flag, 1'b0);
        check("R1", "pulse", tamper_pulse, 1'b0);
        check("R1", "drive", mesh_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle();
        en    = 1'b0;
        fault = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R2", "idle drive", mesh_out, 1'b0);
            check("R2", "idle flag", tamper_flag, 1'b0);
            check("R2", "idle pulse", tamper_pulse, 1'b0);
        end
        fault = 1'b0;
    endtask

    task automatic t_unfiltered();
        logic fl, pl;
        set_div(3);
        filt_en = 1'b0;
        start_run(1'b1);
        for (int i = 0; i < 5; i++) begin
            sample(1'b0, 1'b0, fl, pl);
            check("R4", "no event after faulty settle", fl, 1'b0);
        end
        sample(1'b1, 1'b0, fl, pl);
        check("R5", "single mismatch flag", fl, 1'b1);
        check("R9", "pulse on set", pl, 1'b1);
        sample(1'b0, 1'b0, fl, pl);
        check("R8", "flag held", fl, 1'b1);
        check("R9", "pulse gone", pl, 1'b0);
        sample(1'b0, 1'b1, fl, pl);
        check("R8", "clear in period", fl, 1'b0);
        stop_run();
    endtask

    task automatic t_fast();
        logic fl, pl;
        set_div(0);
        filt_en = 1'b0;
        start_run(1'b0);
        for (int i = 0; i < 3; i++) begin
            sample(1'b0, 1'b0, fl, pl);
            check("R10", "one-cycle period no event", fl, 1'b0);
        end
        sample(1'b1, 1'b0, fl, pl);
        check("R10", "one-cycle detect", fl, 1'b1);
        check("R9", "pulse fast", pl, 1'b1);
        sample(1'b1, 1'b1, fl, pl);
        check("R8", "detect beats clear", fl, 1'b1);
        check("R9", "no pulse while set", pl, 1'b0);
        stop_run();
        clear_idle();
    endtask

    task automatic t_filtered();
        logic fl, pl;
        logic pat [7] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
        set_div(3);
        filt_en = 1'b1;
        start_run(1'b0);
        for (int i = 0; i < 7; i++) begin
            sample(pat[i], 1'b0, fl, pl);
            check("R6", "vote window", fl, (i == 6) ? 1'b1 : 1'b0);
        end
        check("R9", "filtered pulse", pl, 1'b1);
        stop_run();
        clear_idle();
    endtask

    task automatic t_history();
        logic fl, pl;
        set_div(3);
        filt_en = 1'b1;
        start_run(1'b0);
        sample(1'b1, 1'b0, fl, pl);
        check("R6", "lone mismatch", fl, 1'b0);
        stop_run();
        start_run(1'b0);
        sample(1'b1, 1'b0, fl, pl);
        check("R7", "old history discarded", fl, 1'b0);
        sample(1'b1, 1'b0, fl, pl);
        check("R7", "partial window detect", fl, 1'b1);
        stop_run();
        clear_idle();
    endtask

    initial begin
        t_reset();
        t_idle();
        t_unfiltered();
        t_fast();
        t_filtered();
        t_history();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule